// File: doc/BRIEF.md
# Timer and External Interrupt Flag Register

This block is a byte-wide control register at one fixed bus address. It holds the run enables and overflow flags for two timers, and the request flags and trigger-type selects for two active-low external interrupt pins. The timers send one-cycle overflow pulses into the block. The interrupt controller receives the four request flags and sends one acknowledge strobe for each source when it vectors to that source.

Each external pin goes through a two-flop synchronizer inside the block. In edge mode, a falling edge latches a request. That request stays set until the interrupt is vectored or software clears it. In level mode, the request flag is the inverted synchronized pin, so a vector acknowledge has no effect on it.

Top module: `tmr_xint_ctrl`

## Requirements
- R1: The register answers only at address 0x88. Reading it returns {ovf1, run1, ovf0, run0, req1, type1, req0, type0}, bit 7 down to bit 0. Any other address reads 0x00, and a write to any other address changes no bit.
- R2: An overflow pulse on timer i sets overflow flag i at the next clock edge.
- R3: An acknowledge on timer i clears overflow flag i. A software write can set or clear each overflow flag.
- R4: Each run bit changes only on a register write. Run bit i drives `tmr_run_o[i]`.
- R5: When the type bit is 1 (edge mode), a high-to-low transition of the synchronized pin sets the request flag. The flag becomes visible 3 clock edges after the pin falls. A rising pin does not change the flag.
- R6: In edge mode, the vector acknowledge clears the request flag. Software can set or clear the flag.
- R7: When the type bit is 0 (level mode), the request flag equals the inverted pin, delayed by 3 clock edges. Neither the acknowledge nor a software write changes it.
- R8: If a hardware set event (overflow or falling edge) meets a software write or an acknowledge on the same bit in the same cycle, the bit ends up set.
- R9: After reset, every bit is 0. Both timers are stopped and both pins are in level mode.
- R10: A read never changes any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register bus address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| tmr_ovf_i | input | 2 | Overflow pulse, one bit per timer |
| tmr_ack_i | input | 2 | Timer interrupt vector acknowledge |
| xint_n_i | input | 2 | Active-low external interrupt pins (asynchronous) |
| xint_ack_i | input | 2 | External interrupt vector acknowledge |
| tmr_run_o | output | 2 | Timer run enables |
| ovf_flag_o | output | 2 | Timer overflow request flags |
| xint_req_o | output | 2 | External interrupt request flags |

## Verification
The hardest case to reach from the ports is a falling edge that arrives in the very cycle the controller acknowledges the same source. To get there, the bench drops the pin and counts exactly two synchronizer edges, then raises the acknowledge for the one edge on which the edge detector fires. A second hard case is a switch between trigger modes while a request is pending. The write-and-readback table covers it: it flips the type bits while the written request bits are 1, then reads back one cycle later and expects the level-mode flags to have fallen to the pin value.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;
  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned NUM_XINT = 2;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] REG_ADDR = 8'h88;

  // layout: timers in the upper nibble, pins in the lower nibble
  localparam int unsigned TMR_BASE  = 4;
  localparam int unsigned XINT_BASE = 0;

  function automatic int unsigned run_pos(int unsigned i);
    return TMR_BASE + 2 * i;
  endfunction
  function automatic int unsigned ovf_pos(int unsigned i);
    return TMR_BASE + 2 * i + 1;
  endfunction
  function automatic int unsigned type_pos(int unsigned i);
    return XINT_BASE + 2 * i;
  endfunction
  function automatic int unsigned req_pos(int unsigned i);
    return XINT_BASE + 2 * i + 1;
  endfunction
endpackage

// File: rtl/tx_sync2.sv
module tx_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tx_timer_slot.sv
module tx_timer_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_run_i,
  input  logic wr_flag_i,
  input  logic ovf_i,
  input  logic ack_i,
  output logic run_o,
  output logic flag_o
);
  logic run_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en_i) run_q <= wr_run_i;
      // hardware set beats software write, write beats acknowledge
      if (ovf_i)        flag_q <= 1'b1;
      else if (wr_en_i) flag_q <= wr_flag_i;
      else if (ack_i)   flag_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tx_xint_slot.sv
module tx_xint_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_type_i,
  input  logic wr_flag_i,
  input  logic pin_s_i,
  input  logic ack_i,
  output logic edge_mode_o,
  output logic flag_o
);
  logic prev_q, type_q, flag_q, fall;

  assign fall = prev_q & ~pin_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      type_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (wr_en_i) type_q <= wr_type_i;
      if (!type_q)      flag_q <= ~pin_s_i;
      else if (fall)    flag_q <= 1'b1;
      else if (wr_en_i) flag_q <= wr_flag_i;
      else if (ack_i)   flag_q <= 1'b0;
    end
  end

  assign edge_mode_o = type_q;
  assign flag_o      = flag_q;
endmodule

// File: rtl/tmr_xint_ctrl.sv
module tmr_xint_ctrl
  import tmr_xint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_TMR-1:0]  tmr_ovf_i,
  input  logic [NUM_TMR-1:0]  tmr_ack_i,
  input  logic [NUM_XINT-1:0] xint_n_i,
  input  logic [NUM_XINT-1:0] xint_ack_i,
  output logic [NUM_TMR-1:0]  tmr_run_o,
  output logic [NUM_TMR-1:0]  ovf_flag_o,
  output logic [NUM_XINT-1:0] xint_req_o
);
  logic                reg_wr;
  logic [NUM_XINT-1:0] pin_sync;
  logic [NUM_XINT-1:0] xint_type;
  logic [DATA_W-1:0]   reg_view;

  assign reg_wr = bus_we_i && (bus_addr_i == REG_ADDR);

  tx_sync2 #(.W(NUM_XINT), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (xint_n_i),
    .q_o   (pin_sync)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    tx_timer_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (reg_wr),
      .wr_run_i (bus_wdata_i[run_pos(i)]),
      .wr_flag_i(bus_wdata_i[ovf_pos(i)]),
      .ovf_i    (tmr_ovf_i[i]),
      .ack_i    (tmr_ack_i[i]),
      .run_o    (tmr_run_o[i]),
      .flag_o   (ovf_flag_o[i])
    );
    assign reg_view[run_pos(i)] = tmr_run_o[i];
    assign reg_view[ovf_pos(i)] = ovf_flag_o[i];
  end

  for (genvar i = 0; i < NUM_XINT; i++) begin : g_xint
    tx_xint_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (reg_wr),
      .wr_type_i  (bus_wdata_i[type_pos(i)]),
      .wr_flag_i  (bus_wdata_i[req_pos(i)]),
      .pin_s_i    (pin_sync[i]),
      .ack_i      (xint_ack_i[i]),
      .edge_mode_o(xint_type[i]),
      .flag_o     (xint_req_o[i])
    );
    assign reg_view[type_pos(i)] = xint_type[i];
    assign reg_view[req_pos(i)]  = xint_req_o[i];
  end

  assign bus_rdata_o = (bus_addr_i == REG_ADDR) ? reg_view : '0;
endmodule

// File: rtl/tmr_xint_ctrl_chk.sv
module tmr_xint_ctrl_chk
  import tmr_xint_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_wr,
  input logic [NUM_TMR-1:0]  tmr_ovf_i,
  input logic [NUM_TMR-1:0]  tmr_ack_i,
  input logic [NUM_XINT-1:0] xint_ack_i,
  input logic [NUM_TMR-1:0]  tmr_run_o,
  input logic [NUM_TMR-1:0]  ovf_flag_o,
  input logic [NUM_XINT-1:0] xint_req_o,
  input logic [NUM_XINT-1:0] xint_type,
  input logic [NUM_XINT-1:0] pin_sync
);
  p_run_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr |=> $stable(tmr_run_o));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_t
    p_ovf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_ovf_i[i] |=> ovf_flag_o[i]);
    p_tmr_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_ack_i[i] && !tmr_ovf_i[i] && !reg_wr) |=> !ovf_flag_o[i]);
  end

  for (genvar i = 0; i < NUM_XINT; i++) begin : g_x
    p_lvl_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !xint_type[i] |=> (xint_req_o[i] == !$past(pin_sync[i])));
    p_edge_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xint_type[i] && xint_ack_i[i] && pin_sync[i] && !reg_wr) |=> !xint_req_o[i]);
  end
endmodule

bind tmr_xint_ctrl tmr_xint_ctrl_chk u_chk (.*);

// File: tb/tmr_xint_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_xint_ctrl_tb;
  localparam logic [7:0] REG = 8'h88;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = REG;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ovf = '0, tack = '0, pin_n = 2'b11, xack = '0;
  logic [1:0] run, oflag, xreq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_xint_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tmr_ovf_i(ovf),
    .tmr_ack_i(tack), .xint_n_i(pin_n), .xint_ack_i(xack),
    .tmr_run_o(run), .ovf_flag_o(oflag), .xint_req_o(xreq)
  );

  // {write data, expected readback one cycle later}; pins idle high
  localparam logic [15:0] VEC [9] = '{
    16'h55_55, 16'hFF_FF, 16'hAA_A0, 16'h00_00, 16'h0A_00,
    16'h30_30, 16'h05_05, 16'h0F_0F, 16'h00_00
  };

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0; addr = REG;
  endtask

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(rdata, 8'h00, "R9 reset readback");
    rst_n = 1'b1;
    step(2);
    chk({run, oflag, xreq}, 6'h00, "R9 outputs after reset");

    // R1: other address
    wr(8'h89, 8'hFF);
    chk(rdata, 8'h00, "R1 foreign write ignored");
    addr = 8'h89;
    wr(REG, 8'h10);
    addr = 8'h89; #1;
    chk(rdata, 8'h00, "R1 foreign address reads zero");
    addr = REG; #1;
    chk(rdata, 8'h10, "R1 layout run0 bit4");
    chk({6'b0, run}, 8'h01, "R4 run drives tmr_run_o");
    wr(REG, 8'h00);

    // R1 R3 R4 R6 R7: write/readback table
    for (int k = 0; k < 9; k++) begin
      wr(REG, VEC[k][15:8]);
      step(1);
      chk(rdata, VEC[k][7:0], "R1/R3/R4/R6/R7 table");
    end

    // R2 R10 R3
    ovf[1] = 1'b1; step(1); ovf[1] = 1'b0;
    chk({6'b0, oflag}, 8'h02, "R2 overflow sets flag");
    step(3);
    chk(rdata, 8'h80, "R10 read leaves flag set");
    tack[1] = 1'b1; step(1); tack[1] = 1'b0;
    chk(rdata, 8'h00, "R3 timer ack clears");

    // R8 overflow vs write and vs ack
    ovf[0] = 1'b1; addr = REG; wdata = 8'h00; we = 1'b1;
    step(1); ovf[0] = 1'b0; we = 1'b0;
    chk(rdata, 8'h20, "R8 overflow beats write");
    ovf[0] = 1'b1; tack[0] = 1'b1; step(1); ovf[0] = 1'b0; tack[0] = 1'b0;
    chk(rdata, 8'h20, "R8 overflow beats ack");
    wr(REG, 8'h00);

    // R5 edge mode on pin 0
    wr(REG, 8'h01);
    pin_n[0] = 1'b0; step(2);
    chk({6'b0, xreq}, 8'h00, "R5 not yet visible after 2 edges");
    step(1);
    chk({6'b0, xreq}, 8'h01, "R5 falling edge sets at 3rd edge");
    pin_n[0] = 1'b1; step(5);
    chk(rdata, 8'h03, "R5 rising edge leaves flag");
    xack[0] = 1'b1; step(1); xack[0] = 1'b0;
    chk(rdata, 8'h01, "R6 ack clears edge flag");
    step(4);
    chk(rdata, 8'h01, "R5 rising edge does not set");
    wr(REG, 8'h03);
    chk(rdata, 8'h03, "R6 software sets edge flag");
    wr(REG, 8'h01);
    chk(rdata, 8'h01, "R6 software clears edge flag");

    // R7 level mode on pin 1
    wr(REG, 8'h00);
    pin_n[1] = 1'b0; step(3);
    chk(rdata, 8'h08, "R7 level follows low pin");
    xack[1] = 1'b1; step(1); xack[1] = 1'b0;
    chk(rdata, 8'h08, "R7 ack has no effect");
    wr(REG, 8'h00);
    chk(rdata, 8'h08, "R7 write has no effect");
    pin_n[1] = 1'b1; step(2);
    chk(rdata, 8'h08, "R7 three-edge delay");
    step(1);
    chk(rdata, 8'h00, "R7 level follows high pin");

    // R8 falling edge vs ack in edge mode on pin 1
    wr(REG, 8'h04);
    pin_n[1] = 1'b0; step(2);
    xack[1] = 1'b1; step(1); xack[1] = 1'b0;
    chk(rdata, 8'h0C, "R8 edge beats ack");
    pin_n[1] = 1'b1; step(3);

    // R9 reset mid-run
    wr(REG, 8'hFF);
    rst_n = 1'b0; #1;
    chk(rdata, 8'h00, "R9 asynchronous reset clears");
    step(1); rst_n = 1'b1; step(1);
    chk({2'b0, run, oflag, xreq}, 8'h00, "R9 outputs after second reset");

    finish_run();
  end
endmodule